// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers eight maskable interrupt request lines and one non-maskable line and presents a single registered interrupt output to a processor. Each maskable line can be set to trigger on a rising edge or on a held level. A request is first latched as pending. The controller then picks one winner, using either fixed or rotating priority, and raises the interrupt output.

The processor services an interrupt through a small register port. Reading the acknowledge register returns the vector of the winning source and moves that source from pending to active. Writing the end-of-interrupt register later retires the highest-priority active source. A global enable, a per-line mask and a priority threshold restrict which maskable requests are eligible. A request whose level is above the level now running preempts it, so handlers can nest. The non-maskable line ignores the global enable, the mask and the threshold, and it outranks every maskable line.

Register map (3-bit address, 8-bit data): 0 control (bit 0 global enable, bit 1 rotating mode), 1 mask (1 = blocked), 2 trigger (1 = level), 3 threshold (bits 3:0), 4 acknowledge (read), 5 end-of-interrupt (write, data ignored), 6 pending (read), 7 active (read).

Top module: `nest_intc`

## Requirements
- R1: A rising edge on an edge-mode line sets its pending bit. `irq_out` goes high on the fourth rising clock edge after the input rises. Two edges are spent in the synchronizer, one in the pending latch and one in the output register.
- R2: A level-mode line is pending while its input is high and it is not active. If the input is still high when end-of-interrupt retires it, the line is pending again on the next clock. If the input drops before the acknowledge, the request disappears.
- R3: An acknowledge read returns 0x20 plus the line number of the winning eligible source. The same read clears that source's pending bit and sets its active bit.
- R4: An acknowledge read with nothing eligible returns 0xFF and leaves the pending and active state unchanged.
- R5: A write to end-of-interrupt clears only the highest-priority active source. An active non-maskable source is cleared before any maskable one.
- R6: In fixed mode, line 0 has the highest priority and line 7 the lowest.
- R7: In rotating mode, retiring line k makes line k+1 (mod 8) the highest priority and line k the lowest. After reset, line 0 is the highest.
- R8: With the global enable cleared, no maskable line is delivered. A rising edge on the non-maskable input still raises `irq_out`, and its acknowledge returns 0x02.
- R9: A line whose mask bit is 1 is never delivered. Its pending bit is kept, and the line is delivered once it is unmasked.
- R10: A source's level is 8 minus its priority rank, so the top source has level 8 and the lowest has level 1. A source whose level is at or below the threshold value is not eligible.
- R11: An eligible source preempts only when its level is strictly above the level of the highest active source. A running non-maskable source counts as level 9. Other sources wait for end-of-interrupt.
- R12: After reset, `irq_out` is 0 and all configuration, pending and active state reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Maskable request lines, asynchronous |
| nmi_req | input | 1 | Non-maskable request, rising-edge triggered |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
A corrupted pending bit shows up within one cycle on `irq_out` and at the next acknowledge as a wrong vector or a spurious 0xFF. A corrupted active set shows up less directly. It changes which requests are allowed to preempt, and it changes which source the next end-of-interrupt retires. A wrong rotation pointer stays hidden until two sources compete, and then the acknowledge returns the wrong line. The bench therefore reads back the pending and active registers after each acknowledge and each end-of-interrupt, and it compares every vector against a transaction-level model.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // Register addresses of the processor port
   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_MASK   = 3'd1,
      RA_TRIG   = 3'd2,
      RA_THRESH = 3'd3,
      RA_ACK    = 3'd4,
      RA_EOI    = 3'd5,
      RA_PEND   = 3'd6,
      RA_ACTV   = 3'd7
   } nic_addr_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_ROT_BIT = 1;
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nic_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[STAGES-1];

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] base,
   output logic          valid,
   output logic [IW-1:0] idx,
   output logic [IW-1:0] rank
);
   // Scan from base upward with wrap; rank counts steps from base.
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      rank  = '0;
      for (int k = 0; k < N; k++) begin
         int p;
         p = int'(base) + k;
         if (p >= N) p = p - N;
         if (!valid && req[p]) begin
            valid = 1'b1;
            idx   = IW'(p);
            rank  = IW'(k);
         end
      end
   end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
   import nic_pkg::*;
#(
   parameter int          NUM_SRC     = 8,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  VEC_BASE    = 8'h20,
   parameter logic [7:0]  NMI_VEC     = 8'h02,
   parameter logic [7:0]  SPUR_VEC    = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic              nmi_req,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   localparam int IW = $clog2(NUM_SRC);
   localparam int LW = $clog2(NUM_SRC + 2);
   localparam logic [LW-1:0] LVL_TOP = LW'(NUM_SRC);
   localparam logic [LW-1:0] LVL_NMI = LW'(NUM_SRC + 1);

   if (NUM_SRC < 2 || NUM_SRC > DATA_W || (1 << IW) != NUM_SRC) begin : g_bad_src
      $error("nest_intc: NUM_SRC must be a power of two between 2 and DATA_W");
   end
   if (DATA_W < 8 || LW > DATA_W) begin : g_bad_data
      $error("nest_intc: DATA_W too narrow for vectors or threshold");
   end

   // ---------------- input synchronization ----------------
   logic [NUM_SRC:0] s_lvl, s_rise;
   nic_sync #(.W(NUM_SRC + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in ({nmi_req, irq_req}),
      .lvl  (s_lvl),
      .rise (s_rise)
   );

   // ---------------- state ----------------
   logic               en_q, rot_q;
   logic [NUM_SRC-1:0] mask_q, trig_q, pend_q, act_q;
   logic [LW-1:0]      thr_q;
   logic [IW-1:0]      base_q;
   logic               nmi_pend_q, nmi_act_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               irq_q;

   // ---------------- resolution ----------------
   logic [IW-1:0] eff_base;
   logic          pnd_v, act_v;
   logic [IW-1:0] pnd_idx, pnd_rank, act_idx, act_rank;

   assign eff_base = rot_q ? base_q : '0;

   nic_pick #(.N(NUM_SRC), .IW(IW)) u_pick_pend (
      .req  (pend_q & ~mask_q),
      .base (eff_base),
      .valid(pnd_v),
      .idx  (pnd_idx),
      .rank (pnd_rank)
   );

   nic_pick #(.N(NUM_SRC), .IW(IW)) u_pick_act (
      .req  (act_q),
      .base (eff_base),
      .valid(act_v),
      .idx  (act_idx),
      .rank (act_rank)
   );

   logic [LW-1:0] cand_lvl, run_lvl;
   logic          mask_elig, nmi_elig;

   assign cand_lvl = LVL_TOP - LW'(pnd_rank);
   always_comb begin
      if (nmi_act_q)  run_lvl = LVL_NMI;
      else if (act_v) run_lvl = LVL_TOP - LW'(act_rank);
      else            run_lvl = '0;
   end

   assign mask_elig = en_q && pnd_v && (cand_lvl > thr_q) && (cand_lvl > run_lvl);
   assign nmi_elig  = nmi_pend_q && !nmi_act_q;

   // ---------------- handshake decode ----------------
   logic rd_ack, wr_eoi, take_nmi, take_src, eoi_nmi, eoi_src;
   assign rd_ack   = reg_rd && (reg_addr == RA_ACK);
   assign wr_eoi   = reg_wr && (reg_addr == RA_EOI);
   assign take_nmi = rd_ack && nmi_elig;
   assign take_src = rd_ack && !nmi_elig && mask_elig;
   assign eoi_nmi  = wr_eoi && nmi_act_q;
   assign eoi_src  = wr_eoi && !nmi_act_q && act_v;

   logic [NUM_SRC-1:0] take_1h, eoi_1h, act_nxt, pend_nxt;
   assign take_1h = take_src ? (NUM_SRC'(1) << pnd_idx) : '0;
   assign eoi_1h  = eoi_src  ? (NUM_SRC'(1) << act_idx) : '0;
   assign act_nxt = (act_q | take_1h) & ~eoi_1h;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
      if (1) begin : g_line
         always_comb begin
            if (trig_q[i]) pend_nxt[i] = s_lvl[i] && !act_nxt[i];
            else           pend_nxt[i] = (pend_q[i] && !take_1h[i]) || s_rise[i];
         end
      end
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         rot_q      <= 1'b0;
         mask_q     <= '0;
         trig_q     <= '0;
         thr_q      <= '0;
         base_q     <= '0;
         pend_q     <= '0;
         act_q      <= '0;
         nmi_pend_q <= 1'b0;
         nmi_act_q  <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         pend_q     <= pend_nxt;
         act_q      <= act_nxt;
         nmi_pend_q <= (nmi_pend_q && !take_nmi) || s_rise[NUM_SRC];
         nmi_act_q  <= (nmi_act_q || take_nmi) && !eoi_nmi;
         irq_q      <= nmi_elig || mask_elig;
         if (eoi_src && rot_q) base_q <= act_idx + IW'(1);
         if (reg_wr) begin
            case (reg_addr)
               RA_CTRL: begin
                  en_q  <= reg_wdata[CTRL_EN_BIT];
                  rot_q <= reg_wdata[CTRL_ROT_BIT];
               end
               RA_MASK:   mask_q <= reg_wdata[NUM_SRC-1:0];
               RA_TRIG:   trig_q <= reg_wdata[NUM_SRC-1:0];
               RA_THRESH: thr_q  <= reg_wdata[LW-1:0];
               default: ;
            endcase
         end
      end
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         RA_CTRL:   rd_mux = DATA_W'({rot_q, en_q});
         RA_MASK:   rd_mux = DATA_W'(mask_q);
         RA_TRIG:   rd_mux = DATA_W'(trig_q);
         RA_THRESH: rd_mux = DATA_W'(thr_q);
         RA_ACK: begin
            if (nmi_elig)       rd_mux = DATA_W'(NMI_VEC);
            else if (mask_elig) rd_mux = DATA_W'(VEC_BASE + 8'(pnd_idx));
            else                rd_mux = DATA_W'(SPUR_VEC);
         end
         RA_PEND:   rd_mux = DATA_W'(pend_q);
         RA_ACTV:   rd_mux = DATA_W'(act_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;

   assign reg_rdata = rdata_q;
   assign irq_out   = irq_q;

   // ---------------- assertions ----------------
   p_ack_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_src |=> act_q[$past(pnd_idx)]);

   p_spur_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !nmi_elig && !mask_elig && !reg_wr) |=> ($stable(act_q) && $stable(nmi_act_q)));

   p_eoi_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_src && !take_src) |=> ($countones(act_q) + 1 == $countones($past(act_q))));

   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !nmi_elig) |=> !irq_out);

   p_nmi_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_rise[NUM_SRC] |=> nmi_pend_q);

   p_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take_src |-> (!act_v || (pnd_rank < act_rank)));
endmodule

// File: tb/nest_intc_bench.sv
module nest_intc_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       nmi_req = 1'b0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   nest_intc u_nest_intc (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, {24'd0, d}, {24'd0, exp});
   endtask

   // Pulse a set of edge lines and let them settle into pending
   task automatic pulse(input logic [7:0] lines);
      irq_req = lines;
      tick(4);
      irq_req = '0;
      tick(3);
   endtask

   // Model helper: rank*16+idx of first set bit scanning up from base, -1 if none
   function automatic int pick(input logic [7:0] v, input int base);
      for (int k = 0; k < 8; k++) begin
         int p;
         p = (base + k) % 8;
         if (v[p]) return k * 16 + p;
      end
      return -1;
   endfunction

   localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_TRIG = 3'd2, A_THR = 3'd3,
                          A_ACK = 3'd4, A_EOI = 3'd5, A_PEND = 3'd6, A_ACTV = 3'd7;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] m_pend, m_act, m_mask, d;
      int m_base, m_thr, w, a, cand, run;
      bit m_rot;
      void'($urandom(32'h5eed_1234));
      tick(3);
      chk("R12 irq_out in reset", {31'd0, irq_out}, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R12 irq_out after reset", {31'd0, irq_out}, 0);
      rd_chk("R12 ctrl", A_CTRL, 8'h00);
      rd_chk("R12 pend", A_PEND, 8'h00);
      rd_chk("R12 actv", A_ACTV, 8'h00);

      // R1 latency and basic handshake
      wr(A_CTRL, 8'h01);
      @(negedge clk); irq_req = 8'h08;
      tick(3);
      chk("R1 irq_out before 4th edge", {31'd0, irq_out}, 0);
      tick(1);
      chk("R1 irq_out at 4th edge", {31'd0, irq_out}, 1);
      irq_req = '0;
      rd_chk("R1 pend", A_PEND, 8'h08);
      rd_chk("R3 ack vector", A_ACK, 8'h23);
      rd_chk("R3 active set", A_ACTV, 8'h08);
      rd_chk("R3 pending cleared", A_PEND, 8'h00);
      wr(A_EOI, 8'h00);
      rd_chk("R5 eoi clears", A_ACTV, 8'h00);

      // R6 fixed priority, R11 nesting, R4 spurious
      pulse(8'h24);
      rd_chk("R6 line 2 beats line 5", A_ACK, 8'h22);
      rd_chk("R11 lower waits", A_ACK, 8'hFF);
      rd_chk("R4 spurious keeps pend", A_PEND, 8'h20);
      rd_chk("R4 spurious keeps act", A_ACTV, 8'h04);
      pulse(8'h01);
      rd_chk("R11 higher preempts", A_ACK, 8'h20);
      rd_chk("R11 nested active", A_ACTV, 8'h05);
      wr(A_EOI, 8'h00);
      rd_chk("R5 highest cleared first", A_ACTV, 8'h04);
      wr(A_EOI, 8'h00);
      rd_chk("R11 waiting line delivered", A_ACK, 8'h25);
      wr(A_EOI, 8'h00);

      // R9 mask
      wr(A_MASK, 8'h02);
      pulse(8'h02);
      chk("R9 masked no irq", {31'd0, irq_out}, 0);
      rd_chk("R9 masked ack", A_ACK, 8'hFF);
      rd_chk("R9 pending kept", A_PEND, 8'h02);
      wr(A_MASK, 8'h00);
      tick(1);
      chk("R9 unmasked irq", {31'd0, irq_out}, 1);
      rd_chk("R9 unmasked ack", A_ACK, 8'h21);
      wr(A_EOI, 8'h00);

      // R10 threshold
      wr(A_THR, 8'h05);
      pulse(8'h08);
      rd_chk("R10 level 5 blocked", A_ACK, 8'hFF);
      pulse(8'h04);
      rd_chk("R10 level 6 passes", A_ACK, 8'h22);
      wr(A_EOI, 8'h00);
      wr(A_THR, 8'h00);
      rd_chk("R10 threshold lowered", A_ACK, 8'h23);
      wr(A_EOI, 8'h00);

      // R8 global enable and NMI
      wr(A_CTRL, 8'h00);
      pulse(8'h10);
      chk("R8 disabled no irq", {31'd0, irq_out}, 0);
      @(negedge clk); nmi_req = 1'b1;
      tick(4);
      nmi_req = 1'b0;
      chk("R8 nmi raises irq", {31'd0, irq_out}, 1);
      rd_chk("R8 nmi vector", A_ACK, 8'h02);
      rd_chk("R8 maskable blocked", A_ACK, 8'hFF);
      wr(A_CTRL, 8'h01);
      rd_chk("R11 nmi not preempted", A_ACK, 8'hFF);
      wr(A_EOI, 8'h00);
      rd_chk("R5 nmi retired first", A_ACK, 8'h24);
      wr(A_EOI, 8'h00);

      // R2 level trigger
      wr(A_TRIG, 8'h40);
      @(negedge clk); irq_req = 8'h40;
      tick(4);
      rd_chk("R2 level ack", A_ACK, 8'h26);
      wr(A_EOI, 8'h00);
      rd_chk("R2 still high re-pends", A_PEND, 8'h40);
      rd_chk("R2 level ack again", A_ACK, 8'h26);
      irq_req = '0;
      tick(4);
      wr(A_EOI, 8'h00);
      tick(1);
      rd_chk("R2 dropped not pending", A_PEND, 8'h00);
      @(negedge clk); irq_req = 8'h40;
      tick(4);
      irq_req = '0;
      tick(4);
      rd_chk("R2 vanished before ack", A_ACK, 8'hFF);
      wr(A_TRIG, 8'h00);

      // R7 rotating priority
      wr(A_CTRL, 8'h03);
      pulse(8'h42);
      rd_chk("R7 base0 picks line1", A_ACK, 8'h21);
      wr(A_EOI, 8'h00);
      pulse(8'h0A);
      rd_chk("R7 base2 picks line3", A_ACK, 8'h23);
      wr(A_EOI, 8'h00);
      rd_chk("R7 base4 picks line6", A_ACK, 8'h26);
      wr(A_EOI, 8'h00);
      rd_chk("R7 line1 last", A_ACK, 8'h21);
      wr(A_EOI, 8'h00);
      rd_chk("R7 all retired", A_ACTV, 8'h00);

      // Random phase against a transaction model
      rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
      m_pend = '0; m_act = '0; m_mask = '0; m_base = 0; m_thr = 0;
      m_rot = 1'($urandom_range(0, 1));
      wr(A_CTRL, {6'd0, m_rot, 1'b1});
      for (int it = 0; it < 150; it++) begin
         int op;
         op = $urandom_range(0, 5);
         if (op <= 1) begin
            logic [7:0] r;
            r = 8'($urandom);
            pulse(r);
            m_pend = m_pend | r;
         end else if (op <= 3) begin
            w = pick(m_pend & ~m_mask, m_base);
            a = pick(m_act, m_base);
            run = (a < 0) ? 0 : 8 - a / 16;
            cand = (w < 0) ? 0 : 8 - w / 16;
            rd(A_ACK, d);
            if (w >= 0 && cand > m_thr && cand > run) begin
               chk("R3 random ack", {24'd0, d}, 32'h20 + (w % 16));
               m_pend[w % 16] = 1'b0;
               m_act[w % 16] = 1'b1;
            end else begin
               chk("R4 random spurious", {24'd0, d}, 32'hFF);
            end
         end else if (op == 4) begin
            a = pick(m_act, m_base);
            wr(A_EOI, 8'h00);
            if (a >= 0) begin
               m_act[a % 16] = 1'b0;
               if (m_rot) m_base = (a % 16 + 1) % 8;
            end
            rd_chk("R5 R7 random active", A_ACTV, m_act);
         end else begin
            m_mask = 8'($urandom) & 8'($urandom);
            m_thr = $urandom_range(0, 3);
            wr(A_MASK, m_mask);
            wr(A_THR, 8'(m_thr));
            rd_chk("R9 random pending", A_PEND, m_pend);
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule